// File: doc/BRIEF.md
# Audio Master-Mode Clock Generator

This block produces the bit clock and the frame clock for a multichannel audio serial port that runs as clock master. It works from one clock input, `clk`, which runs at twice the audio master clock. All timing is counted in `clk` cycles, one master-clock cycle being two of them. Because of this, the bit clock can also run at the full master-clock rate when the multi-slot framing mode needs it.

A 3-bit rate selector sets how many master-clock cycles make up one sample frame. A mode input chooses between two-channel framing and multi-slot (DSP) framing. A 2-bit word-length selector is used only to detect combinations that cannot be built. The block also exports single-cycle strobes that mark each falling and each rising bit-clock edge, so a serializer in the same clock domain knows when to launch data and when to sample it. All three configuration inputs are latched together at frame boundaries.

Top module: `amclk_gen`

## Requirements
- R1: The frame length in master-clock cycles follows the rate selector: 0→128, 1→192, 2→256, 3→384, 4→512, 5→768, 6→1152. One frame lasts twice that many `clk` cycles.
- R2: With `dsp_en`=0 and rate 0 or 1, the bit clock is the master clock divided by 2: it is low for 2 `clk` cycles, then high for 2, starting low at each frame start.
- R3: With `dsp_en`=0 and rate 2 to 6, the bit clock is the master clock divided by 4: it is low for 4 `clk` cycles, then high for 4, starting low at each frame start.
- R4: With `dsp_en`=1, the bit clock equals the master clock at every rate: it is low for 1 `clk` cycle, then high for 1, starting low at each frame start.
- R5: With `dsp_en`=0, the frame clock is low for the first half of each frame and high for the second half, so it has a 50 % duty cycle.
- R6: With `dsp_en`=1, the frame clock is high for the first bit-clock period of each frame (2 `clk` cycles) and low otherwise. In the first frame after reset it is high only for its first cycle, which is the reset cycle itself, so it reads low throughout.
- R7: The frame clock changes only in a cycle in which the bit clock has just fallen. The one exception is the first cycle after leaving the reserved rate.
- R8: `bit_fall_stb` is high for exactly the cycles in which `bit_clk` has just gone from 1 to 0. `bit_rise_stb` is high for exactly the cycles in which it has just gone from 0 to 1.
- R9: A change of rate, mode or word length takes effect only at the next frame boundary. The frame in progress keeps its timing and its error state.
- R10: `cfg_bad` is high when `dsp_en`=1 with rate 0 and a word length above 16 bits, or with rate 1 and a 32-bit word. Word codes are 0=16, 1=20, 2=24 and 3=32 bits.
- R11: Rate code 7 is reserved. It raises `cfg_bad`, holds both clocks low and keeps the frame counter at its start. A valid code is accepted in the next cycle.
- R12: A synchronous, active-high reset drives both clocks and both strobes low and restarts the frame at its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock at twice the master-clock rate |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 3 | Master-clock-to-sample-rate ratio selector |
| dsp_en | input | 1 | 1 selects multi-slot (DSP) framing |
| word_sel | input | 2 | Word length code (16/20/24/32 bits) |
| bit_clk | output | 1 | Bit clock |
| frame_clk | output | 1 | Frame (left/right or frame-sync) clock |
| bit_fall_stb | output | 1 | One-cycle pulse after a bit-clock falling edge |
| bit_rise_stb | output | 1 | One-cycle pulse after a bit-clock rising edge |
| cfg_bad | output | 1 | Illegal or reserved configuration in effect |

## Verification
The assertions assume that `clk` is the only clock and that the configuration inputs settle before the edge at which a frame boundary may latch them. The frame-clock edge rule also excludes the single cycle after the reserved rate is left. The bench changes its inputs only one time unit after a rising edge. It enters the reserved rate only from reset and never leaves it during a run, so the excluded cycle never comes up. Mid-frame changes are made well away from frame boundaries, so the cycle in which the new setting applies is known exactly.

// File: rtl/amclk_pkg.sv
package amclk_pkg;

   localparam int RATE_W = 3;
   localparam int WORD_W = 2;
   localparam int MAX_MULT = 18;

   typedef struct packed {
      logic [RATE_W-1:0] rate;
      logic              dsp;
      logic [WORD_W-1:0] word;
   } amclk_cfg_t;

   // multiple of the base unit for each rate code; 0 marks the reserved code
   function automatic int unsigned rate_mult(input logic [RATE_W-1:0] code);
      case (code)
         3'd0:    return 2;
         3'd1:    return 3;
         3'd2:    return 4;
         3'd3:    return 6;
         3'd4:    return 8;
         3'd5:    return 12;
         3'd6:    return MAX_MULT;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/amclk_cfg_decode.sv
module amclk_cfg_decode
   import amclk_pkg::*;
#(
   parameter int UNIT  = 64,
   parameter int CNT_W = 12
) (
   input  amclk_cfg_t       cfg,
   output logic [CNT_W-1:0] frame_len,
   output logic [CNT_W-1:0] half_len,
   output logic [1:0]       bit_shift,
   output logic             reserved,
   output logic             illegal
);

   int unsigned mult;

   always_comb begin
      mult      = rate_mult(cfg.rate);
      reserved  = (mult == 0);
      half_len  = CNT_W'(mult * UNIT);
      frame_len = CNT_W'(2 * mult * UNIT);
      if (cfg.dsp)
         bit_shift = 2'd0;
      else if (cfg.rate < 3'd2)
         bit_shift = 2'd1;
      else
         bit_shift = 2'd2;
      illegal = reserved
              | (cfg.dsp & (cfg.rate == 3'd0) & (cfg.word != 2'd0))
              | (cfg.dsp & (cfg.rate == 3'd1) & (cfg.word == 2'd3));
   end

endmodule

// File: rtl/amclk_frame_timer.sv
module amclk_frame_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hold,
   input  logic [CNT_W-1:0] frame_len,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt
);

   always_comb begin
      if (hold || (cnt == frame_len - CNT_W'(1)))
         cnt_nxt = '0;
      else
         cnt_nxt = cnt + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else
         cnt <= cnt_nxt;
   end

endmodule

// File: rtl/amclk_gen.sv
module amclk_gen
   import amclk_pkg::*;
#(
   parameter int UNIT = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic              dsp_en,
   input  logic [WORD_W-1:0] word_sel,
   output logic              bit_clk,
   output logic              frame_clk,
   output logic              bit_fall_stb,
   output logic              bit_rise_stb,
   output logic              cfg_bad
);

   localparam int CNT_W = $clog2(2 * MAX_MULT * UNIT);

   generate
      if (UNIT < 4 || (UNIT % 4) != 0) begin : g_bad_unit
         $error("UNIT must be a positive multiple of 4");
      end
      if (CNT_W < 3) begin : g_bad_width
         $error("frame counter too narrow");
      end
   endgenerate

   amclk_cfg_t cfg_in, cfg_q, cfg_nxt;
   logic [CNT_W-1:0] cnt, cnt_nxt;
   logic [CNT_W-1:0] flen_a, flen_n, half_a, half_n;
   logic [1:0] sh_a, sh_n;
   logic res_a, res_n, bad_a, bad_n;
   logic bclk_nxt, fclk_nxt;

   assign cfg_in = '{rate: rate_sel, dsp: dsp_en, word: word_sel};

   // settings in force now, and settings for the cycle being computed
   amclk_cfg_decode #(.UNIT(UNIT), .CNT_W(CNT_W)) u_dec_act (
      .cfg(cfg_q), .frame_len(flen_a), .half_len(half_a),
      .bit_shift(sh_a), .reserved(res_a), .illegal(bad_a));

   amclk_cfg_decode #(.UNIT(UNIT), .CNT_W(CNT_W)) u_dec_nxt (
      .cfg(cfg_nxt), .frame_len(flen_n), .half_len(half_n),
      .bit_shift(sh_n), .reserved(res_n), .illegal(bad_n));

   amclk_frame_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst(rst), .hold(res_a), .frame_len(flen_a),
      .cnt(cnt), .cnt_nxt(cnt_nxt));

   // new settings are taken only when the counter returns to frame start
   assign cfg_nxt = (cnt_nxt == '0) ? cfg_in : cfg_q;

   always_comb begin
      case (sh_n)
         2'd0:    bclk_nxt = cnt_nxt[0];
         2'd1:    bclk_nxt = cnt_nxt[1];
         default: bclk_nxt = cnt_nxt[2];
      endcase
      if (cfg_nxt.dsp)
         fclk_nxt = (cnt_nxt == '0) | ((cnt_nxt == CNT_W'(1)) & frame_clk);
      else
         fclk_nxt = (cnt_nxt >= half_n);
      if (res_n) begin
         bclk_nxt = 1'b0;
         fclk_nxt = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q        <= cfg_in;
         bit_clk      <= 1'b0;
         frame_clk    <= 1'b0;
         bit_fall_stb <= 1'b0;
         bit_rise_stb <= 1'b0;
      end else begin
         cfg_q        <= cfg_nxt;
         bit_clk      <= bclk_nxt;
         frame_clk    <= fclk_nxt;
         bit_fall_stb <= bit_clk & ~bclk_nxt;
         bit_rise_stb <= ~bit_clk & bclk_nxt;
      end
   end

   assign cfg_bad = bad_a;

   a_r1_cnt_in_frame: assert property (@(posedge clk) disable iff (rst)
      !res_a |-> (cnt < flen_a));
   a_r8_fall_after_high: assert property (@(posedge clk) disable iff (rst)
      bit_fall_stb |-> (!bit_clk && $past(bit_clk)));
   a_r8_rise_after_low: assert property (@(posedge clk) disable iff (rst)
      bit_rise_stb |-> (bit_clk && !$past(bit_clk)));
   a_r7_frame_on_fall: assert property (@(posedge clk) disable iff (rst)
      ((frame_clk != $past(frame_clk)) && !$past(res_a)) |-> bit_fall_stb);
   a_r9_cfg_locked: assert property (@(posedge clk) disable iff (rst)
      (cnt != '0) |-> $stable(cfg_q));
   a_r11_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
      res_a |-> (!bit_clk && !frame_clk && cfg_bad && cnt == '0));

endmodule

// File: tb/amclk_gen_bench.sv
`timescale 1ns/1ps
module amclk_gen_bench;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [2:0] rate_sel = 3'd0;
   logic dsp_en = 1'b0;
   logic [1:0] word_sel = 2'd0;
   logic bit_clk, frame_clk, bit_fall_stb, bit_rise_stb, cfg_bad;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   amclk_gen u_amclk_gen (
      .clk(clk), .rst(rst), .rate_sel(rate_sel), .dsp_en(dsp_en),
      .word_sel(word_sel), .bit_clk(bit_clk), .frame_clk(frame_clk),
      .bit_fall_stb(bit_fall_stb), .bit_rise_stb(bit_rise_stb),
      .cfg_bad(cfg_bad));

   // {rate, dsp, word, expected cfg_bad}
   localparam logic [6:0] VEC [12] = '{
      {3'd0, 1'b0, 2'd3, 1'b0}, {3'd1, 1'b0, 2'd3, 1'b0},
      {3'd2, 1'b0, 2'd0, 1'b0}, {3'd3, 1'b0, 2'd1, 1'b0},
      {3'd4, 1'b0, 2'd2, 1'b0}, {3'd6, 1'b0, 2'd3, 1'b0},
      {3'd0, 1'b1, 2'd0, 1'b0}, {3'd0, 1'b1, 2'd1, 1'b1},
      {3'd1, 1'b1, 2'd2, 1'b0}, {3'd1, 1'b1, 2'd3, 1'b1},
      {3'd5, 1'b1, 2'd3, 1'b0}, {3'd7, 1'b0, 2'd0, 1'b1}};

   function automatic int frame_of(input int rate);
      int m [7] = '{2, 3, 4, 6, 8, 12, 18};
      return (rate > 6) ? 0 : 2 * 64 * m[rate];
   endfunction

   function automatic bit m_bclk(input int p, input int rate, input bit dsp);
      int sh = dsp ? 0 : ((rate < 2) ? 1 : 2);
      if (rate > 6) return 1'b0;
      return 1'((p >> sh) & 1);
   endfunction

   function automatic bit m_fclk(input int p, input int rate, input bit dsp,
                                 input bit first);
      if (rate > 6) return 1'b0;
      if (dsp) return (p == 0) || (p == 1 && !first);
      return p >= frame_of(rate) / 2;
   endfunction

   task automatic check(input bit ok, input string req, input int act,
                        input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset(input int rate, input bit dsp, input int word);
      rate_sel = 3'(rate);
      dsp_en   = dsp;
      word_sel = 2'(word);
      rst      = 1'b1;
      tick();
      tick();
      rst      = 1'b0;
   endtask

   task automatic run_vec(input int rate, input bit dsp, input int word,
                          input bit exp_bad);
      int f = frame_of(rate);
      int span = (f == 0) ? 128 : 2 * f;
      int nb = 0, nf = 0, ns = 0, nbad = 0;
      do_reset(rate, dsp, word);
      for (int k = 1; k <= span; k++) begin
         int p  = (f == 0) ? 0 : k % f;
         int pp = (f == 0) ? 0 : (k - 1) % f;
         bit eb = m_bclk(p, rate, dsp);
         bit pb = (k == 1) ? 1'b0 : m_bclk(pp, rate, dsp);
         bit ef = m_fclk(p, rate, dsp, k < f);
         tick();
         if (bit_clk != eb) nb++;
         if (frame_clk != ef) nf++;
         if (bit_fall_stb != (pb & !eb) || bit_rise_stb != (!pb & eb)) ns++;
         if (cfg_bad != exp_bad) nbad++;
      end
      check(nb == 0, (rate > 6) ? "R11 bit clock" : (dsp ? "R4 bit clock" :
            (rate < 2 ? "R2 bit clock" : "R3 bit clock")), nb, 0);
      check(nf == 0, (rate > 6) ? "R11 frame clock" :
            (dsp ? "R6 frame clock" : "R5 R1 frame clock"), nf, 0);
      check(ns == 0, "R8 R7 edge strobes", ns, 0);
      check(nbad == 0, (rate > 6) ? "R11 cfg_bad" : "R10 cfg_bad", nbad, 0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R12: reset state
      rate_sel = 3'd2;
      tick();
      check({bit_clk, frame_clk, bit_fall_stb, bit_rise_stb} == 4'b0,
            "R12 reset outputs", {bit_clk, frame_clk, bit_fall_stb, bit_rise_stb}, 0);

      for (int i = 0; i < 12; i++)
         run_vec(int'(VEC[i][6:4]), VEC[i][3], int'(VEC[i][2:1]), VEC[i][0]);

      // R12: reset mid-frame forces lows and restarts the frame
      do_reset(2, 1'b0, 0);
      for (int k = 0; k < 13; k++) tick();
      rst = 1'b1;
      tick();
      check({bit_clk, frame_clk, bit_fall_stb, bit_rise_stb} == 4'b0,
            "R12 reset mid-frame", {bit_clk, frame_clk, bit_fall_stb, bit_rise_stb}, 0);
      rst = 1'b0;
      tick(); tick(); tick();
      check(bit_clk == 1'b0, "R12 restart k3", bit_clk, 0);
      tick();
      check(bit_clk == 1'b1 && bit_rise_stb, "R12 restart k4", bit_clk, 1);

      // R9: rate change mid-frame applies at the boundary (256 cycles)
      begin
         int nbo = 0, nfo = 0;
         do_reset(0, 1'b0, 0);
         for (int k = 1; k <= 700; k++) begin
            bit eb, ef;
            if (k < 256) begin
               eb = m_bclk(k, 0, 1'b0);
               ef = m_fclk(k, 0, 1'b0, 1'b0);
            end else begin
               eb = m_bclk(k - 256, 2, 1'b0);
               ef = m_fclk(k - 256, 2, 1'b0, 1'b0);
            end
            tick();
            if (bit_clk != eb) nbo++;
            if (frame_clk != ef) nfo++;
            if (k == 10) rate_sel = 3'd2;
         end
         check(nbo == 0, "R9 bit clock across rate change", nbo, 0);
         check(nfo == 0, "R9 frame clock across rate change", nfo, 0);
      end

      // R9 R10: word length change mid-frame changes cfg_bad at the boundary
      do_reset(0, 1'b1, 0);
      for (int k = 1; k <= 255; k++) begin
         tick();
         if (k == 20) word_sel = 2'd1;
      end
      check(cfg_bad == 1'b0, "R9 cfg_bad held in frame", cfg_bad, 0);
      tick();
      check(cfg_bad == 1'b1, "R10 cfg_bad at boundary", cfg_bad, 1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule